// File: doc/BRIEF.md
# Snoop-Priority Cache Tag Arbiter

This block shares one tag lookup port among three clients of a 4-way, 128-set cache tag store. The clients are core load/store lookups, bus snoop lookups and tag writes, which come from line fills or coherency state updates. Each way of each set holds a tag and a 2-bit coherency state. In any cycle the store does at most one lookup or one write.

A tag write always takes the port for its cycle. A snoop that arrives in the same cycle as a tag write is turned away with a retry strobe, and its requester must ask again. Otherwise a snoop wins over the core. A core access that loses is parked in a one-entry holding register and replayed on the first free cycle. While that register is full, the core sees a stall, and new core requests are not accepted.

Lookup results come back one cycle after the grant. A snoop read that hits a Modified line raises an address-retry indication toward the bus. All addresses at the ports are line addresses, meaning the byte address with its 5 offset bits dropped.

Top module: `snoop_tag_arbiter`

## Requirements
- R1: After reset, all 512 entries read as Invalid, `core_stall` is low, and no response valid is asserted. A lookup made right after reset misses.
- R2: At most one of `snp_gnt` and `core_gnt` is high in any cycle.
- R3: When a snoop and a core access both want the port and no tag write is present, `snp_gnt` is high and `core_gnt` is low in that cycle. The core access is deferred.
- R4: A snoop request in a cycle with `tw_valid` high gets `snp_retry` high and `snp_gnt` low. It produces no snoop response in the next cycle.
- R5: A deferred core access is kept in a one-entry register, and `core_stall` is high from the next cycle while the register is full. The held access is granted in the first cycle with neither `tw_valid` nor `snp_req`, including the cycle right after the snoop that deferred it. A `core_req` presented while `core_stall` is high is ignored: the replay looks up the held address.
- R6: Line address bits [6:0] select the set, and bits [26:7] form the tag. States are encoded as Invalid=00, Shared=01, Exclusive=10 and Modified=11. A lookup hits only when a way's state is not 00 and its tag equals the address tag. On a miss, the reported state is 00 and the way is 0.
- R7: One cycle after a grant, the matching response valid is high and reports hit, way and state.
- R8: `snp_addr_retry` is high exactly when a granted snoop with `snp_is_read`=1 hits a way in state 11. A snoop with `snp_is_read`=0 never raises it.
- R9: A core access presented in a cycle with `tw_valid` high is not granted and is deferred as in R5.
- R10: A tag write to (set, way) is seen by every lookup granted in a later cycle. Writing state 00 removes the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tw_valid | input | 1 | Tag write request, always served this cycle |
| tw_addr | input | 27 | Line address of the tag write |
| tw_way | input | 2 | Way written |
| tw_state | input | 2 | Coherency state written |
| snp_req | input | 1 | Snoop lookup request |
| snp_addr | input | 27 | Snoop line address |
| snp_is_read | input | 1 | Snoop is a read |
| snp_gnt | output | 1 | Snoop lookup performed this cycle |
| snp_retry | output | 1 | Snoop bounced by a tag write, must re-request |
| core_req | input | 1 | Core lookup request |
| core_addr | input | 27 | Core line address |
| core_gnt | output | 1 | Core lookup (held or new) performed this cycle |
| core_stall | output | 1 | Holding register full; new core requests not accepted |
| snp_rsp_valid | output | 1 | Snoop response valid |
| snp_hit | output | 1 | Snoop hit |
| snp_addr_retry | output | 1 | Snoop read hit Modified line |
| snp_rsp_state | output | 2 | State of hit way (00 on miss) |
| core_rsp_valid | output | 1 | Core response valid |
| core_hit | output | 1 | Core hit |
| core_way | output | 2 | Way that hit (0 on miss) |
| core_rsp_state | output | 2 | State of hit way (00 on miss) |

## Verification
The assertions assume that tag writes never leave two valid ways of one set holding the same tag, so that at most one way can match. The bench keeps within this by redirecting each write to the way that already holds that tag, if there is one. They also assume that the core keeps its request meaningful only while `core_stall` is low. The bench still drives random `core_req` values during stalls, so that it can show such requests are ignored. The random phase uses a few sets and tags, which makes hits, Modified snoop hits, write collisions and back-to-back snoops frequent.

// File: rtl/tagarb_pkg.sv
package tagarb_pkg;
  typedef enum logic [1:0] {
    COH_I = 2'b00,
    COH_S = 2'b01,
    COH_E = 2'b10,
    COH_M = 2'b11
  } coh_t;
endpackage

// File: rtl/tagarb_store.sv
module tagarb_store
  import tagarb_pkg::*;
#(
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int LINE_W = 27,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = LINE_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_la,
  input  logic [WAY_W-1:0]  wr_way,
  input  coh_t              wr_state,
  input  logic [LINE_W-1:0] lk_la,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output coh_t              lk_state
);
  function automatic logic [IDX_W-1:0] set_of(input logic [LINE_W-1:0] la);
    return la[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] la);
    return la[LINE_W-1:IDX_W];
  endfunction

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  coh_t             st_q  [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          st_q[s][w]  <= COH_I;
          tag_q[s][w] <= '0;
        end
    end else if (wr_en) begin
      st_q[set_of(wr_la)][wr_way]  <= wr_state;
      tag_q[set_of(wr_la)][wr_way] <= tag_of(wr_la);
    end
  end

  logic [WAYS-1:0] way_match;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_match[w] = (st_q[set_of(lk_la)][w] != COH_I) &&
                          (tag_q[set_of(lk_la)][w] == tag_of(lk_la));
  end

  always_comb begin
    lk_hit   = 1'b0;
    lk_way   = '0;
    lk_state = COH_I;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_match[w]) begin
        lk_hit   = 1'b1;
        lk_way   = WAY_W'(w);
        lk_state = st_q[set_of(lk_la)][w];
      end
    end
  end

  AST_WAY_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match)); // R6
endmodule

// File: rtl/tagarb_sched.sv
module tagarb_sched #(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tw_valid,
  input  logic              snp_req,
  input  logic [LINE_W-1:0] snp_la,
  input  logic              core_req,
  input  logic [LINE_W-1:0] core_la,
  output logic              snp_gnt,
  output logic              snp_retry,
  output logic              core_gnt,
  output logic              core_stall,
  output logic [LINE_W-1:0] lk_la
);
  logic              pend_v;
  logic [LINE_W-1:0] pend_la;
  logic              core_want;
  logic              core_defer;
  logic [LINE_W-1:0] core_sel_la;

  assign core_stall  = pend_v;
  assign core_want   = pend_v | core_req;
  assign core_sel_la = pend_v ? pend_la : core_la;

  assign snp_gnt    = snp_req & ~tw_valid;
  assign snp_retry  = snp_req & tw_valid;
  assign core_gnt   = core_want & ~tw_valid & ~snp_req;
  assign core_defer = core_want & ~core_gnt;
  assign lk_la      = snp_req ? snp_la : core_sel_la;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v  <= 1'b0;
      pend_la <= '0;
    end else if (core_defer) begin
      pend_v  <= 1'b1;
      pend_la <= core_sel_la;
    end else if (core_gnt) begin
      pend_v  <= 1'b0;
    end
  end

  AST_ONE_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_gnt && core_gnt)); // R2
  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_req && !tw_valid) |-> (snp_gnt && !core_gnt)); // R3
  AST_WRITE_BOUNCE: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_req && tw_valid) |-> (snp_retry && !snp_gnt)); // R4
  AST_REPLAY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    core_defer |=> (tw_valid || snp_req || core_gnt)); // R5
  AST_STALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    core_defer |=> core_stall); // R5
  AST_WRITE_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid |-> !core_gnt); // R9
endmodule

// File: rtl/snoop_tag_arbiter.sv
module snoop_tag_arbiter
  import tagarb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tw_valid,
  input  logic [LINE_W-1:0] tw_addr,
  input  logic [WAY_W-1:0]  tw_way,
  input  logic [1:0]        tw_state,
  input  logic              snp_req,
  input  logic [LINE_W-1:0] snp_addr,
  input  logic              snp_is_read,
  output logic              snp_gnt,
  output logic              snp_retry,
  input  logic              core_req,
  input  logic [LINE_W-1:0] core_addr,
  output logic              core_gnt,
  output logic              core_stall,
  output logic              snp_rsp_valid,
  output logic              snp_hit,
  output logic              snp_addr_retry,
  output logic [1:0]        snp_rsp_state,
  output logic              core_rsp_valid,
  output logic              core_hit,
  output logic [WAY_W-1:0]  core_way,
  output logic [1:0]        core_rsp_state
);
  logic [LINE_W-1:0] lk_la;
  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way;
  coh_t              lk_state;

  tagarb_sched #(.LINE_W(LINE_W)) u_sched (
    .clk, .rst_n, .tw_valid, .snp_req,
    .snp_la(snp_addr), .core_req, .core_la(core_addr),
    .snp_gnt, .snp_retry, .core_gnt, .core_stall, .lk_la
  );

  tagarb_store #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_store (
    .clk, .rst_n,
    .wr_en(tw_valid), .wr_la(tw_addr), .wr_way(tw_way),
    .wr_state(coh_t'(tw_state)),
    .lk_la, .lk_hit, .lk_way, .lk_state
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_rsp_valid  <= 1'b0;
      snp_hit        <= 1'b0;
      snp_addr_retry <= 1'b0;
      snp_rsp_state  <= COH_I;
      core_rsp_valid <= 1'b0;
      core_hit       <= 1'b0;
      core_way       <= '0;
      core_rsp_state <= COH_I;
    end else begin
      snp_rsp_valid  <= snp_gnt;
      snp_hit        <= snp_gnt & lk_hit;
      snp_addr_retry <= snp_gnt & snp_is_read & lk_hit & (lk_state == COH_M);
      snp_rsp_state  <= snp_gnt ? lk_state : COH_I;
      core_rsp_valid <= core_gnt;
      core_hit       <= core_gnt & lk_hit;
      core_way       <= core_gnt ? lk_way : '0;
      core_rsp_state <= core_gnt ? lk_state : COH_I;
    end
  end

  AST_SNP_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_gnt |=> snp_rsp_valid); // R7
  AST_CORE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    core_gnt |=> core_rsp_valid); // R7
  AST_RETRY_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |=> !snp_rsp_valid); // R4
  AST_ADDR_RETRY_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    snp_addr_retry |-> (snp_hit && snp_rsp_state == 2'b11)); // R8
  AST_MISS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rsp_valid && !core_hit) |-> (core_rsp_state == 2'b00)); // R6
endmodule

// File: tb/tb_snoop_tag_arbiter.sv
module tb_snoop_tag_arbiter;
  localparam int NS = 128, NW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        tw_valid = 0, snp_req = 0, snp_is_read = 0, core_req = 0;
  logic [26:0] tw_addr = 0, snp_addr = 0, core_addr = 0;
  logic [1:0]  tw_way = 0, tw_state = 0;
  logic        snp_gnt, snp_retry, core_gnt, core_stall;
  logic        snp_rsp_valid, snp_hit, snp_addr_retry, core_rsp_valid, core_hit;
  logic [1:0]  snp_rsp_state, core_way, core_rsp_state;

  snoop_tag_arbiter dut (.*);

  int errors = 0, checks = 0;
  int m_tag [NS*NW];
  int m_st  [NS*NW];
  bit pend_v = 0;
  int pend_a = 0;
  bit e_sv = 0, e_sh = 0, e_sar = 0, e_cv = 0, e_ch = 0;
  int e_ss = 0, e_cw = 0, e_cs = 0;

  bit b_tw, b_sr, b_rd, b_cr;
  int b_ta, b_tw_way, b_tst, b_sa, b_ca;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int la(int tag, int set);
    return (tag << 7) | set;
  endfunction

  task automatic ref_look(input int a, output bit hit, output int way, output int st);
    int s = a % NS;
    int t = a / NS;
    hit = 0; way = 0; st = 0;
    for (int w = NW - 1; w >= 0; w--)
      if (m_st[s*NW+w] != 0 && m_tag[s*NW+w] == t) begin
        hit = 1; way = w; st = m_st[s*NW+w];
      end
  endtask

  task automatic cyc();
    bit want, cg, h;
    int a, wy, st;
    @(negedge clk);
    chk("R7", "snp_rsp_valid", snp_rsp_valid, e_sv);
    if (e_sv) begin
      chk("R6", "snp_hit", snp_hit, e_sh);
      chk("R6", "snp_rsp_state", snp_rsp_state, e_ss);
      chk("R8", "snp_addr_retry", snp_addr_retry, e_sar);
    end
    chk("R7", "core_rsp_valid", core_rsp_valid, e_cv);
    if (e_cv) begin
      chk("R6", "core_hit", core_hit, e_ch);
      chk("R6", "core_way", core_way, e_cw);
      chk("R6", "core_rsp_state", core_rsp_state, e_cs);
    end
    chk("R5", "core_stall", core_stall, pend_v);
    tw_valid = b_tw; tw_addr = 27'(b_ta); tw_way = 2'(b_tw_way); tw_state = 2'(b_tst);
    snp_req = b_sr; snp_addr = 27'(b_sa); snp_is_read = b_rd;
    core_req = b_cr; core_addr = 27'(b_ca);
    #1;
    want = pend_v || b_cr;
    cg = want && !b_tw && !b_sr;
    a = pend_v ? pend_a : b_ca;
    chk("R4", "snp_retry", snp_retry, b_sr && b_tw);
    chk("R3", "snp_gnt", snp_gnt, b_sr && !b_tw);
    chk("R2", "core_gnt", core_gnt, cg);
    e_sv = b_sr && !b_tw;
    ref_look(b_sa, h, wy, st);
    e_sh = e_sv && h; e_ss = e_sv ? st : 0; e_sar = e_sv && b_rd && h && st == 3;
    e_cv = cg;
    ref_look(a, h, wy, st);
    e_ch = cg && h; e_cw = cg ? wy : 0; e_cs = cg ? st : 0;
    if (want && !cg) begin pend_v = 1; pend_a = a; end
    else if (cg) pend_v = 0;
    if (b_tw) begin
      m_st[(b_ta % NS)*NW + b_tw_way] = b_tst;
      m_tag[(b_ta % NS)*NW + b_tw_way] = b_ta / NS;
    end
  endtask

  task automatic idle();
    b_tw = 0; b_sr = 0; b_cr = 0; b_rd = 0;
    b_ta = 0; b_tw_way = 0; b_tst = 0; b_sa = 0; b_ca = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS*NW; i++) begin m_tag[i] = 0; m_st[i] = 0; end
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, then a lookup of tag 0 set 0 misses
    chk("R1", "core_stall", core_stall, 0);
    chk("R1", "rsp_valid", snp_rsp_valid | core_rsp_valid, 0);
    b_cr = 1; b_ca = la(0, 0); cyc(); idle(); cyc();
    chk("R1", "miss_after_reset", core_hit, 0);
    // R10: write Modified tag5 set1 way2 then core lookup hits way2 state 11
    b_tw = 1; b_ta = la(5, 1); b_tw_way = 2; b_tst = 3; cyc(); idle();
    b_cr = 1; b_ca = la(5, 1); cyc(); idle(); cyc();
    chk("R10", "core_way", core_way, 2);
    // R3 R5 R8: snoop read plus core same cycle, replay next cycle
    b_sr = 1; b_rd = 1; b_sa = la(5, 1); b_cr = 1; b_ca = la(5, 1); cyc(); idle();
    cyc();
    chk("R5", "replay_gnt_prev", core_rsp_valid, 0);
    chk("R8", "addr_retry", snp_addr_retry, 1);
    cyc();
    chk("R5", "replay_hit", core_hit, 1);
    // R8: snoop write to Modified line gives no address retry
    b_sr = 1; b_rd = 0; b_sa = la(5, 1); cyc(); idle(); cyc();
    chk("R8", "write_no_retry", snp_addr_retry, 0);
    // R4: snoop colliding with tag write
    b_tw = 1; b_ta = la(7, 2); b_tw_way = 0; b_tst = 1;
    b_sr = 1; b_rd = 1; b_sa = la(5, 1); cyc(); idle(); cyc();
    chk("R4", "no_snoop_rsp", snp_rsp_valid, 0);
    // R9: tag write defers a core access; R5: request during stall ignored
    b_tw = 1; b_ta = la(9, 3); b_tw_way = 1; b_tst = 2; b_cr = 1; b_ca = la(7, 2); cyc(); idle();
    b_sr = 1; b_sa = la(1, 1); b_cr = 1; b_ca = la(9, 3); cyc(); idle();
    b_cr = 1; b_ca = la(9, 3); cyc(); idle(); cyc();
    chk("R5", "held_addr_state", core_rsp_state, 1);
    // R10: invalidating write removes line
    b_tw = 1; b_ta = la(5, 1); b_tw_way = 2; b_tst = 0; cyc(); idle();
    b_cr = 1; b_ca = la(5, 1); cyc(); idle(); cyc();
    chk("R10", "invalidated_miss", core_hit, 0);
    // random phase: small set and tag pool
    for (int n = 0; n < 4000; n++) begin
      idle();
      b_tw = ($urandom % 4) == 0;
      b_sr = ($urandom % 3) == 0;
      b_cr = ($urandom % 2) == 0;
      b_rd = $urandom % 2;
      b_sa = la($urandom % 4, $urandom % 4);
      b_ca = la($urandom % 4, $urandom % 4);
      b_ta = la($urandom % 4, $urandom % 4);
      b_tst = $urandom % 4;
      b_tw_way = $urandom % NW;
      for (int w = 0; w < NW; w++)
        if (m_st[(b_ta % NS)*NW + w] != 0 && m_tag[(b_ta % NS)*NW + w] == b_ta / NS)
          b_tw_way = w;
      cyc();
    end
    idle(); cyc(); cyc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule